// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns a DMA logical address into a physical address by fetching one entry from a translation table that sits in system memory. A requester presents a 32-bit logical address and holds it. The walker works out which 4 KiB page the address falls in and checks that page index against a limit register. If the index is in range, it reads the matching table entry through a simple read master. It then answers with a one-cycle done pulse, the physical address, a fault flag and a two-bit permission field.

The table is one flat array. Each entry is 8 bytes: a frame word, followed by an owner word that the walker never reads. Software programs two registers: a table base, whose top bit the walker ignores, and a table limit given in bytes. A third register offset exists as a no-op invalidate port; writing it has no effect. No entry is cached, so every request produces exactly one table read or one fault.

The walk is driven by a four-state machine:
- `W_IDLE` waits for a request. It moves to `W_ISSUE` when the page is in range, and directly to `W_DONE` when it is out of range.
- `W_ISSUE` drives the read and moves to `W_WAIT` once the read is accepted.
- `W_WAIT` moves to `W_DONE` when the read data returns.
- `W_DONE` pulses done and returns to `W_IDLE`.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, the base and limit registers both read 0, and `rsp_done` and `mrd_valid` are low. Until the limit is programmed, every request faults without issuing a memory read.
- R2: The page index is `req_addr >> 12`. A request is in range only when this index is less than `limit >> 3`. An out-of-range request gives `rsp_done` in the cycle after the clock edge that accepts it, with `rsp_fault`=1, `rsp_perm`=0 and `rsp_paddr`=0. No memory read is issued.
- R3: For an in-range request, `mrd_valid` rises in the cycle after the accepting edge. `mrd_addr` then equals `(base & 0x7FFFFFFF) + index*8`, taken modulo 2^32.
- R4: A returned frame word with no error yields `rsp_fault`=0 and `rsp_perm`=2'b11 (bit 0 grants read, bit 1 grants write). `rsp_paddr` is the frame word's bits 31:12 above the logical address's bits 11:0.
- R5: A read response flagged with `mrd_rsp_err` yields `rsp_fault`=1, `rsp_perm`=0 and `rsp_paddr`=0.
- R6: The base register is at byte offset 0x18 and the limit register at 0x20, and both read back what was written. A write to 0x28 changes neither register nor any later translation. Other offsets read 0 and ignore writes.
- R7: Only one walk is in flight at a time. `mrd_valid` stays high with `mrd_addr` unchanged until `mrd_ready` is sampled high. `rsp_done` lasts exactly one cycle.
- R8: On the walk path, `rsp_done` rises in the cycle after the edge that samples `mrd_rsp_valid`, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Translation request, held until `rsp_done` |
| req_addr | input | 32 | Logical address to translate |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Lookup failed |
| rsp_perm | output | 2 | Bit 0 read, bit 1 write permission |
| mrd_valid | output | 1 | Table read request |
| mrd_addr | output | 32 | Byte address of the frame word |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_rsp_valid | input | 1 | Read data is valid |
| mrd_rsp_data | input | 32 | Frame word |
| mrd_rsp_err | input | 1 | Read failed |

## Verification
Each result has a fixed due cycle, counted from the edge that samples the triggering input:
- An out-of-range fault is due one cycle after the accepting edge.
- The table read is due one cycle after the accepting edge.
- `mrd_valid` falls one cycle after the edge that samples `mrd_ready`.
- The done pulse is due one cycle after the edge that samples the response.

The bench drives each input on a falling edge and samples on the next falling edge, exactly when each result is due. In every idle cycle it inserts while stretching the ready or response wait, it also checks that done has not arrived early. A sweep walks page indices across the limit boundary under several base values, limits, offsets, wait lengths and injected errors. Expected addresses are computed arithmetically from shadow copies of the registers.

// File: rtl/xlw_pkg.sv
package xlw_pkg;
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_DONE  = 2'd3
    } walk_state_e;

    localparam int PERM_W = 2;
    localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;
    localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;
endpackage

// File: rtl/xlw_regs.sv
module xlw_regs #(
    parameter int AW        = 32,
    parameter int CFG_AW    = 8,
    parameter int BASE_OFS  = 'h18,
    parameter int LIMIT_OFS = 'h20,
    parameter int INVAL_OFS = 'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    output logic [AW-1:0]     base_q,
    output logic [AW-1:0]     limit_q
);
    localparam int WORD_W = CFG_AW - 2;
    localparam logic [CFG_AW-1:0] BASE_A  = CFG_AW'(BASE_OFS);
    localparam logic [CFG_AW-1:0] LIMIT_A = CFG_AW'(LIMIT_OFS);
    localparam logic [CFG_AW-1:0] INVAL_A = CFG_AW'(INVAL_OFS);

    logic [WORD_W-1:0] word_sel;
    logic hit_base, hit_limit, hit_inval;
    logic unused_lsb;

    assign word_sel   = cfg_addr[CFG_AW-1:2];
    assign unused_lsb = ^cfg_addr[1:0];
    assign hit_base   = (word_sel == BASE_A[CFG_AW-1:2]);
    assign hit_limit  = (word_sel == LIMIT_A[CFG_AW-1:2]);
    assign hit_inval  = (word_sel == INVAL_A[CFG_AW-1:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (cfg_we) begin
            if (hit_base)  base_q  <= cfg_wdata;
            if (hit_limit) limit_q <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit_base)       cfg_rdata = base_q;
        else if (hit_limit) cfg_rdata = limit_q;
    end

    // R6: the invalidate offset is write-only and inert
    a_r6_inval_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit_inval) |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/xlw_index.sv
module xlw_index #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENT_SHIFT = 3
) (
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          in_range,
    output logic [AW-1:0] ent_addr
);
    localparam logic [AW-1:0] BASE_MASK = {1'b0, {(AW-1){1'b1}}};

    logic [AW-1:0] page_idx;
    logic [AW-1:0] entry_cnt;

    assign page_idx  = laddr >> PAGE_BITS;
    assign entry_cnt = limit >> ENT_SHIFT;
    assign in_range  = (page_idx < entry_cnt);
    assign ent_addr  = (base & BASE_MASK) + (page_idx << ENT_SHIFT);
endmodule

// File: rtl/xlw_fsm.sv
module xlw_fsm
    import xlw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [PAGE_BITS-1:0] req_off,
    input  logic                 in_range,
    input  logic [AW-1:0]        ent_addr,
    output logic                 rsp_done,
    output logic [AW-1:0]        rsp_paddr,
    output logic                 rsp_fault,
    output logic [PERM_W-1:0]    rsp_perm,
    output logic                 mrd_valid,
    output logic [AW-1:0]        mrd_addr,
    input  logic                 mrd_ready,
    input  logic                 mrd_rsp_valid,
    input  logic [AW-1:0]        mrd_rsp_data,
    input  logic                 mrd_rsp_err
);
    walk_state_e state_q, state_d;

    logic [AW-1:0]        ent_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [AW-1:0]        paddr_q;
    logic                 fault_q;
    logic [PERM_W-1:0]    perm_q;
    logic                 accept, accept_oob, rsp_take;
    logic                 unused_frame_lsb;

    assign unused_frame_lsb = ^mrd_rsp_data[PAGE_BITS-1:0];
    assign accept     = (state_q == W_IDLE) && req_valid;
    assign accept_oob = accept && !in_range;
    assign rsp_take   = (state_q == W_WAIT) && mrd_rsp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (req_valid) state_d = in_range ? W_ISSUE : W_DONE;
            W_ISSUE: if (mrd_ready) state_d = W_WAIT;
            W_WAIT:  if (mrd_rsp_valid) state_d = W_DONE;
            W_DONE:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    // walk context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q   <= '0;
            off_q   <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            perm_q  <= PERM_NONE;
        end else begin
            if (accept) begin
                ent_q <= ent_addr;
                off_q <= req_off;
            end
            if (accept_oob || (rsp_take && mrd_rsp_err)) begin
                paddr_q <= '0;
                fault_q <= 1'b1;
                perm_q  <= PERM_NONE;
            end else if (rsp_take) begin
                paddr_q <= {mrd_rsp_data[AW-1:PAGE_BITS], off_q};
                fault_q <= 1'b0;
                perm_q  <= PERM_RW;
            end
        end
    end

    // outputs
    always_comb begin
        mrd_valid = (state_q == W_ISSUE);
        mrd_addr  = ent_q;
        rsp_done  = (state_q == W_DONE);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
        rsp_perm  = perm_q;
    end

    a_r2_oob_short: assert property (@(posedge clk) disable iff (!rst_n)
        accept_oob |=> (rsp_done && rsp_fault && !mrd_valid && rsp_perm == PERM_NONE));

    a_r3_issue_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_range) |=> (mrd_valid && mrd_addr == $past(ent_addr)));

    a_r4_frame_used: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && !mrd_rsp_err) |=> (rsp_done && !rsp_fault && rsp_perm == PERM_RW
            && rsp_paddr[AW-1:PAGE_BITS] == $past(mrd_rsp_data[AW-1:PAGE_BITS])));

    a_r5_err_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && mrd_rsp_err) |=> (rsp_done && rsp_fault && rsp_paddr == '0));

    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r7_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrd_valid) |-> $past(req_valid));
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import xlw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CFG_AW    = 8,
    parameter int PAGE_BITS = 12,
    parameter int ENT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_done,
    output logic [AW-1:0]     rsp_paddr,
    output logic              rsp_fault,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              mrd_valid,
    output logic [AW-1:0]     mrd_addr,
    input  logic              mrd_ready,
    input  logic              mrd_rsp_valid,
    input  logic [AW-1:0]     mrd_rsp_data,
    input  logic              mrd_rsp_err
);
    logic [AW-1:0] base_q, limit_q, ent_addr;
    logic          in_range;

    xlw_regs #(.AW(AW), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .base_q(base_q), .limit_q(limit_q)
    );

    xlw_index #(.AW(AW), .PAGE_BITS(PAGE_BITS), .ENT_SHIFT(ENT_SHIFT)) u_index (
        .laddr(req_addr), .base(base_q), .limit(limit_q),
        .in_range(in_range), .ent_addr(ent_addr)
    );

    xlw_fsm #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_off(req_addr[PAGE_BITS-1:0]), .in_range(in_range), .ent_addr(ent_addr),
        .rsp_done(rsp_done), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_perm(rsp_perm), .mrd_valid(mrd_valid), .mrd_addr(mrd_addr),
        .mrd_ready(mrd_ready), .mrd_rsp_valid(mrd_rsp_valid),
        .mrd_rsp_data(mrd_rsp_data), .mrd_rsp_err(mrd_rsp_err)
    );
endmodule

// File: tb/sim_dma_xlate_walker.sv
module sim_dma_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_done, rsp_fault, mrd_valid;
    logic [31:0] rsp_paddr, mrd_addr;
    logic [1:0]  rsp_perm;
    logic        mrd_ready = 1'b0, mrd_rsp_valid = 1'b0, mrd_rsp_err = 1'b0;
    logic [31:0] mrd_rsp_data = '0;

    always #4 clk = ~clk;

    dma_xlate_walker u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_perm(rsp_perm), .mrd_valid(mrd_valid),
        .mrd_addr(mrd_addr), .mrd_ready(mrd_ready), .mrd_rsp_valid(mrd_rsp_valid),
        .mrd_rsp_data(mrd_rsp_data), .mrd_rsp_err(mrd_rsp_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_limit = '0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input logic [31:0] ea);
        return (ea * 32'h0001_0DCD) ^ 32'h5A5A_3C3C;
    endfunction

    task automatic cfg_wr(input logic [7:0] ofs, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ofs == 8'h18) m_base = val;
        if (ofs == 8'h20) m_limit = val;
    endtask

    task automatic cfg_rd(input logic [7:0] ofs, input logic [31:0] exp, input string rq);
        cfg_addr = ofs;
        #1;
        chk(cfg_rdata == exp, rq, cfg_rdata, exp);
    endtask

    task automatic walk(input logic [31:0] la, input int rdy_wait, input int rsp_wait, input bit err);
        logic [31:0] idx, ea, fr, exp_pa;
        bit inr;
        idx = la >> 12;
        inr = (idx < (m_limit >> 3));
        ea  = (m_base & 32'h7FFF_FFFF) + (idx << 3);
        fr  = frame_of(ea);
        exp_pa = {fr[31:12], la[11:0]};
        @(negedge clk);
        req_valid = 1'b1; req_addr = la;
        @(negedge clk);
        if (!inr) begin
            chk(rsp_done == 1'b1, "R2 oob done", {31'b0, rsp_done}, 32'd1);
            chk(rsp_fault == 1'b1, "R2 oob fault", {31'b0, rsp_fault}, 32'd1);
            chk(rsp_paddr == 32'd0, "R2 oob paddr", rsp_paddr, 32'd0);
            chk(rsp_perm == 2'b00, "R2 oob perm", {30'b0, rsp_perm}, 32'd0);
            chk(mrd_valid == 1'b0, "R2 oob no read", {31'b0, mrd_valid}, 32'd0);
            req_valid = 1'b0;
        end else begin
            chk(mrd_valid == 1'b1, "R3 read issued", {31'b0, mrd_valid}, 32'd1);
            chk(mrd_addr == ea, "R3 entry address", mrd_addr, ea);
            chk(rsp_done == 1'b0, "R7 no done while reading", {31'b0, rsp_done}, 32'd0);
            for (int k = 0; k < rdy_wait; k++) begin
                @(negedge clk);
                chk(mrd_valid && mrd_addr == ea, "R7 read held", mrd_addr, ea);
            end
            mrd_ready = 1'b1;
            @(negedge clk);
            mrd_ready = 1'b0;
            chk(mrd_valid == 1'b0, "R7 read retired", {31'b0, mrd_valid}, 32'd0);
            for (int k = 0; k < rsp_wait; k++) begin
                @(negedge clk);
                chk(rsp_done == 1'b0, "R8 no early done", {31'b0, rsp_done}, 32'd0);
            end
            mrd_rsp_valid = 1'b1; mrd_rsp_data = fr; mrd_rsp_err = err;
            @(negedge clk);
            mrd_rsp_valid = 1'b0; mrd_rsp_err = 1'b0;
            chk(rsp_done == 1'b1, "R8 done after response", {31'b0, rsp_done}, 32'd1);
            if (err) begin
                chk(rsp_fault == 1'b1, "R5 error fault", {31'b0, rsp_fault}, 32'd1);
                chk(rsp_paddr == 32'd0, "R5 error paddr", rsp_paddr, 32'd0);
                chk(rsp_perm == 2'b00, "R5 error perm", {30'b0, rsp_perm}, 32'd0);
            end else begin
                chk(rsp_fault == 1'b0, "R4 no fault", {31'b0, rsp_fault}, 32'd0);
                chk(rsp_paddr == exp_pa, "R4 physical address", rsp_paddr, exp_pa);
                chk(rsp_perm == 2'b11, "R4 read/write perm", {30'b0, rsp_perm}, 32'd3);
            end
            req_valid = 1'b0;
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R7 done is one cycle", {31'b0, rsp_done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_done == 1'b0, "R1 reset done low", {31'b0, rsp_done}, 32'd0);
        chk(mrd_valid == 1'b0, "R1 reset read low", {31'b0, mrd_valid}, 32'd0);
        cfg_rd(8'h18, 32'd0, "R1 reset base");
        cfg_rd(8'h20, 32'd0, "R1 reset limit");
        rst_n = 1'b1;
        // R1: unprogrammed limit faults every lookup
        walk(32'h0000_0123, 0, 0, 1'b0);
        walk(32'hFFFF_F000, 0, 0, 1'b0);

        // R6: register access
        cfg_wr(8'h18, 32'h8000_2000);
        cfg_wr(8'h20, 32'd43);
        cfg_rd(8'h18, 32'h8000_2000, "R6 base readback");
        cfg_rd(8'h20, 32'd43, "R6 limit readback");
        cfg_wr(8'h28, 32'hFFFF_FFFF);
        cfg_rd(8'h18, 32'h8000_2000, "R6 base after invalidate");
        cfg_rd(8'h20, 32'd43, "R6 limit after invalidate");
        cfg_rd(8'h28, 32'd0, "R6 invalidate reads zero");
        cfg_wr(8'h30, 32'h1234_5678);
        cfg_rd(8'h30, 32'd0, "R6 unmapped offset");

        // sweep across the boundary: limit 43 gives 5 entries
        for (int i = 0; i < 8; i++)
            walk({i[19:0], 12'(i * 397)}, i % 3, i % 2, (i == 2));

        // R6: invalidate between identical lookups changes nothing
        walk(32'h0000_3ABC, 1, 0, 1'b0);
        cfg_wr(8'h28, 32'h0);
        walk(32'h0000_3ABC, 0, 1, 1'b0);

        // exact multiple of 8: index 4 in, 5 out
        cfg_wr(8'h20, 32'd40);
        cfg_wr(8'h18, 32'hFFFF_FFF8);
        for (int i = 3; i < 7; i++)
            walk({i[19:0], 12'hFFF}, 2, 2, 1'b0);

        // full-range limit, high page index
        cfg_wr(8'h20, 32'hFFFF_FFFF);
        cfg_wr(8'h18, 32'h7FFF_0000);
        walk(32'hFFFF_FABC, 0, 3, 1'b0);
        walk(32'h8000_0001, 3, 0, 1'b1);
        walk(32'h0000_0000, 0, 0, 1'b0);

        // limit below one entry
        cfg_wr(8'h20, 32'd7);
        walk(32'h0000_0FFF, 0, 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule